// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block is the transmit-side queue manager of a descriptor-driven Ethernet MAC. Software builds two-word transmit descriptors in a ring held in system memory and credits them to the engine one at a time with an enqueue pulse. The engine reads each credited descriptor through a request/valid memory-read port. It hands the buffer address, length, index and end-of-frame marker to a frame sender, then waits for the sender's completion report. That report carries a success flag, a collision count and error flags.

For each descriptor the engine composes a single 32-bit status word and stores it through a request/acknowledge memory-write port into a second ring. It then raises a transmit interrupt status bit. Both rings are defined by a base address and a byte length, and each ring's pointer returns to its base when it reaches the end. A descriptor whose abort flag is set is never offered to the sender. It is retired straight away with an aborted status. Only one frame is in flight at any time.

Top module: `tx_queue_engine`

## Requirements
- R1: After reset `rd_req`, `snd_valid`, `wr_req`, `int_stat` and `tx_irq` are all 0.
- R2: A descriptor fetch starts only when the credit count is nonzero and both `bm_tx_en` and `tx_en` are 1. The fetch is two reads: first at the current descriptor address (buffer word), then at that address plus 4 (control word). With no credit, or with either enable low, `rd_req` stays 0.
- R3: For a descriptor whose control word has bit 15 clear, `snd_valid` offers `snd_addr` (the buffer word), `snd_len` (bits 11:0), `snd_idx` (bits 30:16) and `snd_eof` (bit 31). The offer is held unchanged until `snd_ready` is 1. Bits 14:12 are ignored.
- R4: When control bit 15 (abort) is 1, the descriptor is never offered to the sender. Its status word has bit 31 and bit 29 set, bit 30 clear, collision count 0, and the descriptor index.
- R5: The status word has bit 31 = 1 (processed) and bit 30 = `done_ok`. Bits 29, 28, 26, 25 and 24 take `done_err` bits 4, 3, 2, 1 and 0 (aborted, carrier lost, late collision, underrun, excessive collisions). Bits 20:16 hold `done_ncoll` and bits 14:0 hold the descriptor index. All other bits are 0.
- R6: The n-th status word goes to `stat_base` + 4·n, and the offset wraps to 0 when it reaches `stat_blen`.
- R7: The descriptor address advances by 8 per fetched descriptor and returns to `desc_base` when the offset reaches `desc_blen`.
- R8: Each `enq_pulse` cycle adds one credit, up to RING_ENTRIES; pulses beyond that are ignored. One credit is consumed when a status write is acknowledged.
- R9: `int_stat` becomes 1 in the cycle after a status write is acknowledged, and an `int_clr` pulse returns it to 0.
- R10: `tx_irq` is 1 exactly when `int_stat`, `int_en` and `glob_int_en` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_tx_en | input | 1 | Bus-master transmit enable |
| tx_en | input | 1 | Transmitter enable |
| int_en | input | 1 | Transmit interrupt enable |
| glob_int_en | input | 1 | Global interrupt enable |
| desc_base | input | AW | Descriptor ring base address |
| desc_blen | input | AW | Descriptor ring length in bytes |
| stat_base | input | AW | Status ring base address |
| stat_blen | input | AW | Status ring length in bytes |
| enq_pulse | input | 1 | One cycle credits one descriptor |
| int_clr | input | 1 | Clears the interrupt status bit |
| rd_req | output | 1 | Memory read request, held until rd_valid |
| rd_addr | output | AW | Memory read address |
| rd_valid | input | 1 | Read data valid / request done |
| rd_data | input | 32 | Read data |
| snd_valid | output | 1 | Frame offer to the sender |
| snd_ready | input | 1 | Sender accepts the offer |
| snd_addr | output | 32 | Buffer address |
| snd_len | output | 12 | Buffer length in bytes |
| snd_idx | output | 15 | Descriptor buffer index |
| snd_eof | output | 1 | Last buffer of frame |
| done_valid | input | 1 | Sender completion strobe |
| done_ok | input | 1 | Frame sent without error |
| done_ncoll | input | 5 | Collisions seen |
| done_err | input | 5 | {aborted, carrier lost, late collision, underrun, excessive collisions} |
| wr_req | output | 1 | Memory write request, held until wr_ack |
| wr_addr | output | AW | Status write address |
| wr_data | output | 32 | Status word |
| wr_ack | input | 1 | Write accepted |
| int_stat | output | 1 | Transmit interrupt status |
| tx_irq | output | 1 | Gated transmit interrupt |

## Verification
The bench uses the default parameters: 32-bit addresses and RING_ENTRIES of 8. The descriptor ring is 64 bytes at 0x1000 and the status ring is 32 bytes at 0x2000. With these values both pointers wrap every eight frames, so more than forty frames cross the wrap point several times. Eight credits are enough to fill the ring, which lets a burst of eleven enqueue pulses show the cap.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int WORD_W  = 32;
  localparam int LEN_W   = 12;
  localparam int IDX_W   = 15;
  localparam int NCOLL_W = 5;
  localparam int ERR_W   = 5;

  // control word field positions (decoded by the engine)
  localparam int C_EOF   = 31;
  localparam int C_IDX_L = 16;
  localparam int C_ABORT = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_BUF,
    ST_FETCH_CTL,
    ST_SEND,
    ST_WAIT_DONE,
    ST_POST
  } txq_state_e;

  typedef struct packed {
    logic aborted;
    logic no_carrier;
    logic late_coll;
    logic underrun;
    logic excess_coll;
  } txq_err_t;

  function automatic logic [WORD_W-1:0] txq_status_word(
    input logic               ok,
    input txq_err_t           e,
    input logic [NCOLL_W-1:0] ncoll,
    input logic [IDX_W-1:0]   idx
  );
    logic [WORD_W-1:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30]    = ok;
    w[29]    = e.aborted;
    w[28]    = e.no_carrier;
    w[26]    = e.late_coll;
    w[25]    = e.underrun;
    w[24]    = e.excess_coll;
    w[20:16] = ncoll;
    w[14:0]  = idx;
    return w;
  endfunction

endpackage

// File: rtl/txq_credit.sv
module txq_credit #(
  parameter int MAX = 8,
  parameter int CW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic          take,
  output logic [CW-1:0] cnt,
  output logic          has_work
);

  localparam logic [CW-1:0] CAP = CW'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (enq && !take) begin
      if (cnt != CAP) cnt <= cnt + 1'b1;
    end else if (take && !enq) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign has_work = (cnt != '0);

  a_r8_never_above_ring: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  a_r8_take_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_work);

  a_r8_full_ignores_enq: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !take && cnt == CAP) |=> cnt == CAP);

endmodule

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] blen,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] off;

  function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] o,
                                               input logic [AW-1:0] l);
    logic [AW-1:0] n;
    n = o + STEP_V;
    return (n >= l) ? '0 : n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   off <= '0;
    else if (adv) off <= wrap_next(off, blen);
  end

  assign addr = base + off;

  a_r7_offset_stays_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && blen >= STEP_V && $stable(blen)) |=> off < blen);

  a_r7_idle_pointer_still: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> off == $past(off));

endmodule

// File: rtl/txq_irq.sv
module txq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  input  logic ge,
  output logic stat,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)   stat <= 1'b0;
    else if (set) stat <= 1'b1;
    else if (clr) stat <= 1'b0;
  end

  assign irq = stat & ie & ge;

  a_r9_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> stat);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !stat);

endmodule

// File: rtl/tx_queue_engine.sv
module tx_queue_engine #(
  parameter int AW           = 32,
  parameter int RING_ENTRIES = 8,
  parameter int DESC_BYTES   = 8,
  parameter int STAT_BYTES   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bm_tx_en,
  input  logic          tx_en,
  input  logic          int_en,
  input  logic          glob_int_en,
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] desc_blen,
  input  logic [AW-1:0] stat_base,
  input  logic [AW-1:0] stat_blen,
  input  logic          enq_pulse,
  input  logic          int_clr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          snd_valid,
  input  logic          snd_ready,
  output logic [31:0]   snd_addr,
  output logic [11:0]   snd_len,
  output logic [14:0]   snd_idx,
  output logic          snd_eof,
  input  logic          done_valid,
  input  logic          done_ok,
  input  logic [4:0]    done_ncoll,
  input  logic [4:0]    done_err,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic          int_stat,
  output logic          tx_irq
);
  import txq_pkg::*;

  localparam int CW = $clog2(RING_ENTRIES + 1);
  localparam logic [AW-1:0] CTL_OFS = AW'(DESC_BYTES / 2);

  txq_state_e        state, state_n;
  logic [WORD_W-1:0] buf_q, ctl_q, status_q;
  logic [AW-1:0]     desc_addr, stat_addr;
  logic [CW-1:0]     credit;
  logic              has_credit;

  // named events, shared by the datapath and the assertions
  logic engine_go, buf_fetched, ctl_fetched, ctl_abort, offer_taken;
  logic report_in, frame_posted;

  assign engine_go    = (state == ST_IDLE) && has_credit && bm_tx_en && tx_en;
  assign buf_fetched  = (state == ST_FETCH_BUF) && rd_valid;
  assign ctl_fetched  = (state == ST_FETCH_CTL) && rd_valid;
  assign ctl_abort    = rd_data[C_ABORT];
  assign offer_taken  = (state == ST_SEND) && snd_ready;
  assign report_in    = (state == ST_WAIT_DONE) && done_valid;
  assign frame_posted = (state == ST_POST) && wr_ack;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:      if (engine_go)    state_n = ST_FETCH_BUF;
      ST_FETCH_BUF: if (buf_fetched)  state_n = ST_FETCH_CTL;
      ST_FETCH_CTL: if (ctl_fetched)  state_n = ctl_abort ? ST_POST : ST_SEND;
      ST_SEND:      if (offer_taken)  state_n = ST_WAIT_DONE;
      ST_WAIT_DONE: if (report_in)    state_n = ST_POST;
      ST_POST:      if (frame_posted) state_n = ST_IDLE;
      default:                        state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      buf_q    <= '0;
      ctl_q    <= '0;
      status_q <= '0;
    end else begin
      state <= state_n;
      if (buf_fetched) buf_q <= rd_data;
      if (ctl_fetched) begin
        ctl_q <= rd_data;
        if (ctl_abort)
          status_q <= txq_status_word(1'b0, txq_err_t'(5'b10000), '0,
                                      rd_data[C_IDX_L +: IDX_W]);
      end
      if (report_in)
        status_q <= txq_status_word(done_ok, txq_err_t'(done_err), done_ncoll,
                                    ctl_q[C_IDX_L +: IDX_W]);
    end
  end

  txq_credit #(.MAX(RING_ENTRIES), .CW(CW)) u_credit (
    .clk(clk), .rst_n(rst_n), .enq(enq_pulse), .take(frame_posted),
    .cnt(credit), .has_work(has_credit)
  );

  txq_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_desc_ptr (
    .clk(clk), .rst_n(rst_n), .base(desc_base), .blen(desc_blen),
    .adv(ctl_fetched), .addr(desc_addr)
  );

  txq_ring_ptr #(.AW(AW), .STEP(STAT_BYTES)) u_stat_ptr (
    .clk(clk), .rst_n(rst_n), .base(stat_base), .blen(stat_blen),
    .adv(frame_posted), .addr(stat_addr)
  );

  txq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(frame_posted), .clr(int_clr),
    .ie(int_en), .ge(glob_int_en), .stat(int_stat), .irq(tx_irq)
  );

  assign rd_req    = (state == ST_FETCH_BUF) || (state == ST_FETCH_CTL);
  assign rd_addr   = (state == ST_FETCH_CTL) ? desc_addr + CTL_OFS : desc_addr;
  assign snd_valid = (state == ST_SEND);
  assign snd_addr  = buf_q;
  assign snd_len   = ctl_q[LEN_W-1:0];
  assign snd_idx   = ctl_q[C_IDX_L +: IDX_W];
  assign snd_eof   = ctl_q[C_EOF];
  assign wr_req    = (state == ST_POST);
  assign wr_addr   = stat_addr;
  assign wr_data   = status_q;

  a_r2_fetch_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> has_credit);

  a_r2_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(bm_tx_en && tx_en)) |=> !rd_req);

  a_r3_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready) |=> snd_valid && $stable(snd_addr) && $stable(snd_len)
                                  && $stable(snd_idx));

  a_r4_abort_never_offered: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> !ctl_q[C_ABORT]);

  a_r5_processed_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_data[31]);

  a_r6_status_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && stat_blen != '0) |-> (wr_addr - stat_base) < stat_blen);

  a_r9_status_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat) |-> $past(wr_req && wr_ack));

endmodule

// File: tb/tx_queue_engine_bench.sv
module tx_queue_engine_bench;

  localparam int AW = 32;
  localparam logic [31:0] DBASE = 32'h1000;
  localparam logic [31:0] DLEN  = 32'd64;
  localparam logic [31:0] SBASE = 32'h2000;
  localparam logic [31:0] SLEN  = 32'd32;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bm_tx_en = 0, tx_en = 0, int_en = 0, glob_int_en = 0;
  logic enq_pulse = 0, int_clr = 0;
  logic rd_req, rd_valid = 0;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic snd_valid, snd_ready = 0, snd_eof;
  logic [31:0] snd_addr;
  logic [11:0] snd_len;
  logic [14:0] snd_idx;
  logic done_valid = 0, done_ok = 0;
  logic [4:0] done_ncoll = '0, done_err = '0;
  logic wr_req, wr_ack = 0;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic int_stat, tx_irq;

  always #4 clk = ~clk;

  tx_queue_engine u_tx_queue_engine (
    .clk(clk), .rst_n(rst_n), .bm_tx_en(bm_tx_en), .tx_en(tx_en),
    .int_en(int_en), .glob_int_en(glob_int_en),
    .desc_base(DBASE), .desc_blen(DLEN), .stat_base(SBASE), .stat_blen(SLEN),
    .enq_pulse(enq_pulse), .int_clr(int_clr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_addr(snd_addr),
    .snd_len(snd_len), .snd_idx(snd_idx), .snd_eof(snd_eof),
    .done_valid(done_valid), .done_ok(done_ok), .done_ncoll(done_ncoll),
    .done_err(done_err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .int_stat(int_stat), .tx_irq(tx_irq)
  );

  int total = 0, fails = 0;
  logic [31:0] dbuf [SLOTS];
  logic [31:0] dctl [SLOTS];
  int outstanding = 0, completed = 0;
  int sw_slot = 0, hw_slot = 0, st_slot = 0;
  bit word_hi = 0;
  logic [31:0] cur_buf, cur_ctl, exp_word;
  bit exp_abort = 0, await_done = 0;
  int done_delay = 0, snd_wait = 0, irq_phase = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // status word as the requirements state it
  function automatic logic [31:0] exp_stat(input bit ok, input bit [4:0] err,
                                           input bit [4:0] nc, input logic [31:0] ctl);
    logic [31:0] w;
    w = 32'h8000_0000;
    if (ok)     w = w | (32'd1 << 30);
    if (err[4]) w = w | (32'd1 << 29);
    if (err[3]) w = w | (32'd1 << 28);
    if (err[2]) w = w | (32'd1 << 26);
    if (err[1]) w = w | (32'd1 << 25);
    if (err[0]) w = w | (32'd1 << 24);
    w = w | (32'(nc) << 16);
    w = w | ((ctl >> 16) & 32'h7fff);
    return w;
  endfunction

  // memory, sender and interrupt-handler model
  initial begin
    forever begin
      @(negedge clk);
      // completion report (before the sender, so it never coincides with ready)
      if (done_valid) done_valid = 0;
      else if (await_done) begin
        if (done_delay > 0) done_delay--;
        else begin
          bit ok; bit [4:0] er; bit [4:0] nc;
          ok = ($urandom % 4) != 0;
          er = 5'($urandom);
          nc = 5'($urandom);
          done_ok = ok; done_err = er; done_ncoll = nc; done_valid = 1;
          exp_word = exp_stat(ok, er, nc, cur_ctl);
          await_done = 0;
        end
      end
      // read port
      if (rd_valid) rd_valid = 0;
      else if (rd_req) begin
        chk(word_hi ? "R2 ctl addr" : "R7 buf addr", rd_addr,
            DBASE + 32'(hw_slot * 8) + (word_hi ? 32'd4 : 32'd0));
        rd_data = word_hi ? dctl[hw_slot] : dbuf[hw_slot];
        rd_valid = 1;
        if (word_hi) begin
          cur_buf = dbuf[hw_slot];
          cur_ctl = dctl[hw_slot];
          exp_abort = cur_ctl[15];
          if (exp_abort) exp_word = exp_stat(0, 5'b10000, 5'd0, cur_ctl);
          hw_slot = (hw_slot + 1) % SLOTS;
        end
        word_hi = !word_hi;
      end
      // sender
      if (snd_ready) snd_ready = 0;
      else if (snd_valid) begin
        if (exp_abort) chk("R4 aborted offered", 32'(snd_valid), 32'd0);
        if (snd_wait > 0) snd_wait--;
        else begin
          chk("R3 addr", snd_addr, cur_buf);
          chk("R3 len", 32'(snd_len), cur_ctl & 32'hfff);
          chk("R3 idx", 32'(snd_idx), (cur_ctl >> 16) & 32'h7fff);
          chk("R3 eof", 32'(snd_eof), 32'(cur_ctl[31]));
          snd_ready = 1;
          await_done = 1;
          done_delay = $urandom % 4;
          snd_wait = $urandom % 3;
        end
      end
      // interrupt handler
      if (irq_phase == 2) begin
        int_clr = 0;
        chk("R9 cleared", 32'(int_stat), 32'd0);
        irq_phase = 0;
      end else if (irq_phase == 1) begin
        chk("R9 set", 32'(int_stat), 32'd1);
        chk("R10 gate", 32'(tx_irq), 32'(int_en & glob_int_en));
        int_clr = 1;
        irq_phase = 2;
      end
      // write port
      if (wr_ack) begin
        wr_ack = 0;
        irq_phase = 1;
      end else if (wr_req) begin
        chk("R6 status addr", wr_addr, SBASE + 32'(st_slot * 4));
        chk(exp_abort ? "R4 status" : "R5 status", wr_data, exp_word);
        wr_ack = 1;
        st_slot = (st_slot + 1) % SLOTS;
        outstanding--;
        completed++;
      end
    end
  end

  task automatic enq_frame(input bit abort, input bit nowait);
    if (!nowait) while (outstanding >= SLOTS) @(negedge clk);
    @(negedge clk);
    int_en = 1'($urandom);
    glob_int_en = 1'($urandom);
    if (outstanding < SLOTS) begin
      dbuf[sw_slot] = $urandom;
      dctl[sw_slot] = {1'($urandom), 15'($urandom), abort, 3'($urandom), 12'($urandom)};
      sw_slot = (sw_slot + 1) % SLOTS;
      outstanding++;
    end
    enq_pulse = 1;
    @(negedge clk);
    enq_pulse = 0;
  endtask

  task automatic watch_quiet(input string req, input int cycles);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rd_req) seen++;
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  task automatic drain();
    while (outstanding != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int base_done;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 snd_valid", 32'(snd_valid), 0);
    chk("R1 wr_req", 32'(wr_req), 0);
    chk("R1 int_stat", 32'(int_stat), 0);
    chk("R1 tx_irq", 32'(tx_irq), 0);

    // R2: bus-master enable low blocks fetch
    tx_en = 1;
    enq_frame(0, 0);
    enq_frame(0, 0);
    watch_quiet("R2 bm enable low", 20);
    bm_tx_en = 1;
    drain();
    chk("R2 frames after enable", 32'(completed), 32'd2);

    // R2: transmitter enable low blocks fetch
    tx_en = 0;
    enq_frame(0, 0);
    watch_quiet("R2 tx enable low", 20);
    tx_en = 1;
    drain();

    // directed abort descriptor
    enq_frame(1, 0);
    drain();
    chk("R4 abort retired", 32'(completed), 32'd4);

    // random traffic across several wraps
    for (int n = 0; n < 44; n++) enq_frame(($urandom % 6) == 0, 0);
    drain();
    chk("R7 all random frames", 32'(completed), 32'd48);

    // R8: credit saturates at the ring size
    bm_tx_en = 0;
    base_done = completed;
    for (int n = 0; n < 11; n++) enq_frame(0, 1);
    watch_quiet("R2 saturate hold", 10);
    bm_tx_en = 1;
    drain();
    chk("R8 capped credit", 32'(completed - base_done), 32'd8);
    watch_quiet("R8 no extra fetch", 30);
    chk("R2 empty idle", 32'(rd_req), 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule